// File: doc/BRIEF.md
# Receive Descriptor Ring Poll Controller

This block decides when a receive engine walks a circular list of buffer descriptors kept in memory. Software produces free buffers, sets their empty marker and then strobes a command register. The strobe arms an active flag. While that flag and the global enable are both high, the controller reads descriptors one after another through a simple memory read port. Each descriptor found empty is offered to a downstream frame writer on a valid/ready channel as a buffer address and length.

The ring pointer starts at a programmable base. It moves forward one 8-byte descriptor each time the frame writer accepts a buffer. It jumps back to the base when the accepted descriptor carries a wrap marker. The first descriptor found not empty ends the walk: the flag drops and the pointer stays on that descriptor until software strobes the command register again. Dropping the global enable cancels everything. The flag clears and the pointer returns to the base.

Each descriptor is one 64-bit word:
- bits 63:32: buffer address
- bits 31:16: buffer length
- bit 15: empty marker
- bit 13: wrap marker

Top module: `rx_ring_poller`

## Requirements
- R1: A one-cycle pulse on `cmd_wr` while `en` is high sets the active flag. From the next cycle, `cmd_rdata` reads 32'h0100_0000: the flag is in bit 24 and every other bit is zero.
- R2: `mem_req` stays low whenever the active flag or `en` is low.
- R3: A fetched descriptor with bit 15 clear is not offered on `buf_valid`. The flag reads zero from the cycle after its read data returns. No further fetch is made, and the pointer is not advanced: the next armed fetch uses the same address.
- R4: While `en` is low, the flag is clear, `buf_valid` is low and a `cmd_wr` pulse has no effect. After `en` rises again, the first fetch addresses `base_addr`.
- R5: A fetched descriptor with bit 15 set is offered with `buf_addr` equal to bits 63:32 and `buf_len` equal to bits 31:16. Both are held stable, with `buf_valid` high, until `buf_ready` is seen.
- R6: After an accepted offer, the next fetch addresses the previous fetch address plus 8 when the accepted descriptor has bit 13 clear.
- R7: After an accepted offer of a descriptor with bit 13 set, the next fetch addresses `base_addr`.
- R8: At most one fetch is outstanding. `mem_req` stays high with a stable `mem_addr` until `mem_gnt`, and no new request is made before `mem_rvalid` returns.
- R9: A `cmd_wr` pulse in the same cycle that a not-empty descriptor is returned leaves the flag set, and polling continues with another fetch.
- R10: After reset, `cmd_rdata`, `mem_req` and `buf_valid` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Global controller enable |
| base_addr | input | AW | Ring base byte address |
| cmd_wr | input | 1 | Command register write strobe (data ignored) |
| cmd_rdata | output | 32 | Command register read value, flag in bit 24 |
| mem_req | output | 1 | Descriptor read request |
| mem_addr | output | AW | Descriptor read address |
| mem_gnt | input | 1 | Read request accepted |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 64 | Descriptor word |
| buf_valid | output | 1 | Empty buffer offered |
| buf_addr | output | 32 | Offered buffer address |
| buf_len | output | 16 | Offered buffer length |
| buf_ready | input | 1 | Frame writer accepts the buffer |

## Verification
A wrong pointer shows up on `mem_addr` at the very next request after an accepted offer or a stop. That happens within two cycles of the handshake, so a missed wrap or a skipped advance is caught there. A wrong active flag appears on `cmd_rdata` bit 24 one cycle after the strobe or the returned descriptor. It also appears as a request made, or missing, on the cycle after that. A sequencer that loses track of the outstanding read either issues a second request before `mem_rvalid` or never offers a buffer. Either fault is visible within a few cycles on the memory or buffer ports.

// File: rtl/rdesc_pkg.sv
package rdesc_pkg;
  localparam int DESC_W    = 64;
  localparam int EMPTY_BIT = 15;
  localparam int WRAP_BIT  = 13;
  localparam int LEN_LSB   = 16;
  localparam int LEN_W     = 16;
  localparam int BADDR_LSB = 32;
  localparam int BADDR_W   = 32;
  localparam int FLAG_POS  = 24;
  localparam int STEP      = 8;

  typedef enum logic [2:0] {
    S_IDLE  = 3'd0,
    S_REQ   = 3'd1,
    S_WAIT  = 3'd2,
    S_OFFER = 3'd3,
    S_DRAIN = 3'd4
  } seq_state_t;
endpackage

// File: rtl/rdesc_active_flag.sv
module rdesc_active_flag (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic cmd_wr,
  input  logic stop,
  output logic active
);
  always_ff @(posedge clk) begin
    if (rst || !en)  active <= 1'b0;
    else if (cmd_wr) active <= 1'b1;
    else if (stop)   active <= 1'b0;
  end

  p_arm_r1: assert property (@(posedge clk) disable iff (rst)
    (en && cmd_wr) |=> active);
  p_off_r4: assert property (@(posedge clk) disable iff (rst)
    !en |=> !active);
  p_keep_r9: assert property (@(posedge clk) disable iff (rst)
    (en && cmd_wr && stop) |=> active);
endmodule

// File: rtl/rdesc_ring_ptr.sv
module rdesc_ring_ptr #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic [AW-1:0] base_addr,
  input  logic          adv,
  input  logic          wrap,
  output logic [AW-1:0] ptr
);
  import rdesc_pkg::*;
  localparam logic [AW-1:0] STEP_A = AW'(STEP);

  always_ff @(posedge clk) begin
    if (rst || !en)  ptr <= base_addr;
    else if (adv)    ptr <= wrap ? base_addr : ptr + STEP_A;
  end

  p_step_r6: assert property (@(posedge clk) disable iff (rst)
    (en && adv && !wrap) |=> (ptr == $past(ptr) + STEP_A));
  p_wrap_r7: assert property (@(posedge clk) disable iff (rst)
    (en && adv && wrap) |=> (ptr == $past(base_addr)));
endmodule

// File: rtl/rdesc_fetch_seq.sv
module rdesc_fetch_seq #(
  parameter int AW = 32
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        en,
  input  logic                        active,
  input  logic [AW-1:0]               ptr,
  output logic                        mem_req,
  output logic [AW-1:0]               mem_addr,
  input  logic                        mem_gnt,
  input  logic                        mem_rvalid,
  input  logic [rdesc_pkg::DESC_W-1:0] mem_rdata,
  output logic                        buf_valid,
  output logic [rdesc_pkg::BADDR_W-1:0] buf_addr,
  output logic [rdesc_pkg::LEN_W-1:0] buf_len,
  input  logic                        buf_ready,
  output logic                        stop,
  output logic                        adv,
  output logic                        wrap
);
  import rdesc_pkg::*;

  seq_state_t state;
  logic       wrap_q;
  logic       got_data;

  assign got_data  = mem_rvalid && (state == S_WAIT);
  assign mem_req   = (state == S_REQ);
  assign mem_addr  = ptr;
  assign buf_valid = (state == S_OFFER);
  assign stop      = en && got_data && !mem_rdata[EMPTY_BIT];
  assign adv       = en && (state == S_OFFER) && buf_ready;
  assign wrap      = wrap_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= S_IDLE;
      wrap_q   <= 1'b0;
      buf_addr <= '0;
      buf_len  <= '0;
    end else if (!en) begin
      if ((state == S_WAIT && !mem_rvalid) || (state == S_REQ && mem_gnt))
        state <= S_DRAIN;
      else if (state != S_DRAIN)
        state <= S_IDLE;
      else if (mem_rvalid)
        state <= S_IDLE;
    end else begin
      case (state)
        S_IDLE:  if (active) state <= S_REQ;
        S_REQ:   if (mem_gnt) state <= S_WAIT;
        S_WAIT:  if (mem_rvalid) begin
                   if (mem_rdata[EMPTY_BIT]) begin
                     state    <= S_OFFER;
                     buf_addr <= mem_rdata[BADDR_LSB +: BADDR_W];
                     buf_len  <= mem_rdata[LEN_LSB +: LEN_W];
                     wrap_q   <= mem_rdata[WRAP_BIT];
                   end else begin
                     state <= S_IDLE;
                   end
                 end
        S_OFFER: if (buf_ready) state <= S_IDLE;
        S_DRAIN: if (mem_rvalid) state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  p_off_idle_r2: assert property (@(posedge clk) disable iff (rst)
    (!en || !active) && state != S_REQ |=> !mem_req);
  p_req_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (en && mem_req && !mem_gnt) |=> (mem_req && $stable(mem_addr)));
  p_ret_expected_r8: assert property (@(posedge clk) disable iff (rst)
    mem_rvalid |-> (state == S_WAIT || state == S_DRAIN));
  p_buf_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (en && buf_valid && !buf_ready) |=> (buf_valid && $stable(buf_addr) && $stable(buf_len)));
  p_no_offer_r3: assert property (@(posedge clk) disable iff (rst)
    stop |=> !buf_valid);
endmodule

// File: rtl/rx_ring_poller.sv
module rx_ring_poller #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic [AW-1:0] base_addr,
  input  logic          cmd_wr,
  output logic [31:0]   cmd_rdata,
  output logic          mem_req,
  output logic [AW-1:0] mem_addr,
  input  logic          mem_gnt,
  input  logic          mem_rvalid,
  input  logic [63:0]   mem_rdata,
  output logic          buf_valid,
  output logic [31:0]   buf_addr,
  output logic [15:0]   buf_len,
  input  logic          buf_ready
);
  import rdesc_pkg::*;

  logic          active, stop, adv, wrap;
  logic [AW-1:0] ptr;

  rdesc_active_flag u_flag (
    .clk(clk), .rst(rst), .en(en), .cmd_wr(cmd_wr), .stop(stop), .active(active)
  );

  rdesc_ring_ptr #(.AW(AW)) u_ptr (
    .clk(clk), .rst(rst), .en(en), .base_addr(base_addr),
    .adv(adv), .wrap(wrap), .ptr(ptr)
  );

  rdesc_fetch_seq #(.AW(AW)) u_seq (
    .clk(clk), .rst(rst), .en(en), .active(active), .ptr(ptr),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_gnt(mem_gnt),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
    .buf_valid(buf_valid), .buf_addr(buf_addr), .buf_len(buf_len),
    .buf_ready(buf_ready), .stop(stop), .adv(adv), .wrap(wrap)
  );

  always_comb begin
    cmd_rdata           = '0;
    cmd_rdata[FLAG_POS] = active;
  end

  p_rd_zero_r1: assert property (@(posedge clk) disable iff (rst)
    $countones(cmd_rdata) <= 1);
endmodule

// File: tb/tb_rx_ring_poller.sv
module tb_rx_ring_poller;
  localparam int AW = 32;
  localparam logic [31:0] BASE = 32'h0000_0100;
  localparam logic [31:0] FLAG = 32'h0100_0000;
  // descriptor = {addr[31:0], len[15:0], flags[15:0]}; empty=bit15, wrap=bit13
  localparam logic [63:0] TBL [3] = '{
    {32'h1000_0000, 16'h0040, 16'h8000},
    {32'h1000_1000, 16'h05EE, 16'h8000},
    {32'h1000_2000, 16'h0100, 16'hA000}
  };

  logic          clk = 0, rst = 1, en = 0, cmd_wr = 0, buf_ready = 0, gnt_ok = 1;
  logic [AW-1:0] base_addr = BASE;
  logic [31:0]   cmd_rdata;
  logic          mem_req, mem_gnt, mem_rvalid = 0, buf_valid;
  logic [AW-1:0] mem_addr;
  logic [63:0]   mem_rdata = '0;
  logic [31:0]   buf_addr;
  logic [15:0]   buf_len;
  logic [63:0]   mem [8];
  logic [31:0]   last_gnt_addr = '0;
  int            gcount = 0, checks = 0, failures = 0;
  bit            done = 0;

  always #4 clk = ~clk;

  rx_ring_poller #(.AW(AW)) dut (
    .clk(clk), .rst(rst), .en(en), .base_addr(base_addr), .cmd_wr(cmd_wr),
    .cmd_rdata(cmd_rdata), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_gnt(mem_gnt), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
    .buf_valid(buf_valid), .buf_addr(buf_addr), .buf_len(buf_len),
    .buf_ready(buf_ready)
  );

  assign mem_gnt = mem_req && gnt_ok;

  always @(posedge clk) begin
    mem_rvalid <= mem_req && mem_gnt;
    if (mem_req && mem_gnt) begin
      mem_rdata     <= mem[3'((mem_addr - BASE) >> 3)];
      last_gnt_addr <= mem_addr;
      gcount        <= gcount + 1;
    end
  end

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  task automatic pulse_wr();
    cmd_wr = 1; @(negedge clk); cmd_wr = 0;
  endtask

  task automatic wait_valid(string tag);
    for (int k = 0; k < 50 && !buf_valid; k++) @(negedge clk);
    chk({tag, " buf_valid seen"}, buf_valid, 1);
  endtask

  task automatic wait_flag_low(string tag);
    for (int k = 0; k < 50 && cmd_rdata[24]; k++) @(negedge clk);
    chk({tag, " flag dropped"}, cmd_rdata, 0);
  endtask

  task automatic accept();
    buf_ready = 1; @(negedge clk); buf_ready = 0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog (R2) actual=hung expected=finished");
      finish_run();
    end
  end

  initial begin
    int g0;
    for (int i = 0; i < 8; i++) mem[i] = 64'h0;
    for (int i = 0; i < 3; i++) mem[i] = TBL[i];
    repeat (2) @(negedge clk);
    rst = 0;
    chk("R10 cmd_rdata", cmd_rdata, 0);
    chk("R10 mem_req", mem_req, 0);
    chk("R10 buf_valid", buf_valid, 0);

    // R4: write while disabled is ignored
    pulse_wr();
    chk("R4 flag after disabled write", cmd_rdata, 0);
    repeat (3) @(negedge clk);
    chk("R2 no request while disabled", mem_req, 0);
    en = 1;
    repeat (3) @(negedge clk);
    chk("R2 no request without flag", mem_req, 0);

    // R1 arm
    pulse_wr();
    chk("R1 cmd_rdata armed", cmd_rdata, FLAG);

    // vector walk: R5, R6, R7
    for (int i = 0; i < 3; i++) begin
      wait_valid("R5");
      chk("R5 buf_addr", buf_addr, TBL[i][63:32]);
      chk("R5 buf_len", buf_len, TBL[i][31:16]);
      chk("R6 fetch address", last_gnt_addr, BASE + 32'(8 * i));
      repeat (2) @(negedge clk);
      chk("R5 held valid", buf_valid, 1);
      chk("R5 held addr", buf_addr, TBL[i][63:32]);
      accept();
      mem[i][15] = 1'b0;
    end

    // after wrap, desc 0 is fetched and now not empty
    wait_flag_low("R3");
    chk("R7 fetch back at base", last_gnt_addr, BASE);
    chk("R3 no offer", buf_valid, 0);
    g0 = gcount;
    repeat (4) @(negedge clk);
    chk("R3 no further fetch", gcount, g0);

    // R3 pointer not advanced
    pulse_wr();
    wait_flag_low("R3 rearm");
    chk("R3 same address refetched", last_gnt_addr, BASE);

    // R9 collision
    g0 = gcount;
    pulse_wr();
    for (int k = 0; k < 50 && !mem_rvalid; k++) @(negedge clk);
    pulse_wr();
    chk("R9 flag kept", cmd_rdata, FLAG);
    wait_flag_low("R9");
    chk("R9 second fetch made", gcount - g0, 2);

    // R8 grant stall
    gnt_ok = 0;
    g0 = gcount;
    pulse_wr();
    repeat (4) @(negedge clk);
    chk("R8 request held", mem_req, 1);
    chk("R8 address held", mem_addr, BASE);
    chk("R8 no grant counted", gcount, g0);
    gnt_ok = 1;
    wait_flag_low("R8");
    chk("R8 single fetch", gcount - g0, 1);

    // R4 enable drop mid-ring
    mem[0] = TBL[0]; mem[1] = TBL[1];
    pulse_wr();
    wait_valid("R4 first");
    accept();
    wait_valid("R4 second");
    chk("R6 second fetch address", last_gnt_addr, BASE + 32'd8);
    en = 0;
    @(negedge clk);
    chk("R4 flag cleared", cmd_rdata, 0);
    chk("R4 offer withdrawn", buf_valid, 0);
    en = 1;
    @(negedge clk);
    pulse_wr();
    wait_valid("R4 restart");
    chk("R4 restart at base", last_gnt_addr, BASE);
    chk("R5 restart buf_addr", buf_addr, TBL[0][63:32]);
    accept();

    done = 1;
    finish_run();
  end
endmodule